// File: doc/BRIEF.md
# External Pin Interrupt Conditioner

This block turns a small group of external interrupt pins into per-pin interrupt requests for a downstream interrupt controller. Each pin is first brought into the clock domain through a synchronizer. It is then judged by its own trigger mode: active-low level, rising edge, falling edge or either edge. In the edge modes a detected transition sets a sticky flag. The flag holds the request until software clears it by writing a one to that bit. In level mode the request simply follows the synchronized pin.

Software programs the block over a small register bus with separate read and write strobes. There are four registers. A 16-bit trigger-mode register holds a 2-bit field per pin. There is also an enable register, a direction register and the flag register, each 8 bits wide. The direction bits are kept only so software can read them back; they drive nothing. Bit position 0 exists in every register but is reserved: it can never raise a request or set a flag.

Top module: `pin_event_unit`

## Requirements
- R1: After reset every register reads zero, so all pins are level-mode inputs with interrupts disabled, and `irq_req` is all zero.
- R2: The trigger-mode register is 16 bits wide and holds pin n's field at bits [2n+1:2n]. A full read-back returns exactly what was written. Rewriting it with only one field changed alters only that pin's behaviour.
- R3: Field encodings are 2'b00 level, 2'b01 rising edge, 2'b10 falling edge and 2'b11 both edges. A transition of the other polarity does not set the flag in a single-edge mode.
- R4: Each pin passes through a two-flop synchronizer. A level-mode request appears after the second rising clock edge following a pin change. An edge-mode flag and its request appear after the third rising edge, and not before.
- R5: Level mode is active-low. The request is high while the synchronized pin is 0, falls when the pin returns to 1, and never sets a flag.
- R6: Flag register bits are write-1-to-clear. Writing 1 clears that flag and writing 0 leaves it as it was.
- R7: `irq_req[n]` is high only when enable bit n is 1. Flags still latch while the pin is disabled, and a pending flag raises the request as soon as the pin is enabled.
- R8: The direction register is stored and read back only, with 0 meaning input. Its value has no effect on requests.
- R9: Position 0 is reserved. Whatever its mode, enable or pin activity, `irq_req[0]` stays 0 and flag bit 0 stays 0.
- R10: If a new edge and a write-1-to-clear reach the same flag in the same cycle, the flag stays set.
- R11: Register addresses are 0 mode, 1 enable, 2 direction and 3 flag. The 8-bit registers sit in data bits [7:0], and their upper data bits are ignored on write and read as 0. Read data is valid on the cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| ext_pin | input | 8 | Raw external pins, idle high |
| irq_req | output | 8 | Per-pin interrupt request |

## Verification
The bench builds the block with its default parameters: eight bit positions and a two-stage synchronizer. With these values every trigger mode can be placed on its own pin at the same time. The reserved position can be given an edge mode and enabled, to show it stays silent. The short synchronizer also keeps the exact cycle of each level and edge response easy to pin down, so the checks sample the request on the cycle before it is due and on the cycle it is due. A second edge is lined up with a clear write on the same cycle to exercise the edge-wins rule.

// File: rtl/epi_pkg.sv
package epi_pkg;

    localparam int POS_N_DEF  = 8;
    localparam int SYNC_N_DEF = 2;
    localparam int ADDR_W     = 2;

    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'b00,
        TRIG_RISE  = 2'b01,
        TRIG_FALL  = 2'b10,
        TRIG_BOTH  = 2'b11
    } trig_e;

    typedef enum logic [ADDR_W-1:0] {
        RA_MODE   = 2'd0,
        RA_ENABLE = 2'd1,
        RA_DIR    = 2'd2,
        RA_FLAG   = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/epi_sync.sv
module epi_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.chain[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            st_d.chain[k] = st_q.chain[k-1];
        end
    end

    // Idle pins are high, so the chain starts high to avoid a false edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.chain[STAGES-1];

endmodule

// File: rtl/epi_pin_cell.sv
module epi_pin_cell
    import epi_pkg::*;
#(
    parameter bit RESV = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp,
    input  logic [1:0] mode,
    input  logic       en,
    input  logic       clr,
    output logic       evt,
    output logic       flag,
    output logic       req
);

    typedef struct packed {
        logic prev;
        logic flag;
    } cell_st_t;

    cell_st_t st_d, st_q;
    logic     rise, fall, hit, src;

    always_comb begin
        rise = smp & ~st_q.prev;
        fall = ~smp & st_q.prev;
        unique case (trig_e'(mode))
            TRIG_LEVEL: hit = 1'b0;
            TRIG_RISE:  hit = rise;
            TRIG_FALL:  hit = fall;
            TRIG_BOTH:  hit = rise | fall;
            default:    hit = 1'b0;
        endcase
        if (RESV) begin
            hit = 1'b0;
        end
        // A fresh edge outranks a clear in the same cycle.
        st_d.prev = smp;
        st_d.flag = hit | (st_q.flag & ~clr);
        src       = (trig_e'(mode) == TRIG_LEVEL) ? ~smp : st_q.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{prev: 1'b1, flag: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign evt  = hit;
    assign flag = st_q.flag;
    assign req  = en & src & ~RESV;

endmodule

// File: rtl/epi_regs.sv
module epi_regs
    import epi_pkg::*;
#(
    parameter int POS_N = 8,
    parameter int BUS_W = 2 * POS_N
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr,
    input  logic                 rd,
    input  logic [BUS_W-1:0]     wdata,
    input  logic [POS_N-1:0]     flags,
    output logic [BUS_W-1:0]     rdata,
    output logic [2*POS_N-1:0]   mode_vec,
    output logic [POS_N-1:0]     en_vec,
    output logic [POS_N-1:0]     dir_vec,
    output logic [POS_N-1:0]     clr_vec
);

    localparam int PAD_W = BUS_W - POS_N;

    typedef struct packed {
        logic [2*POS_N-1:0] mode;
        logic [POS_N-1:0]   en;
        logic [POS_N-1:0]   dir;
        logic [BUS_W-1:0]   rdata;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        clr_vec = '0;
        if (wr) begin
            unique case (reg_addr_e'(addr))
                RA_MODE:   st_d.mode = wdata[2*POS_N-1:0];
                RA_ENABLE: st_d.en   = wdata[POS_N-1:0];
                RA_DIR:    st_d.dir  = wdata[POS_N-1:0];
                RA_FLAG:   clr_vec   = wdata[POS_N-1:0];
                default:   ;
            endcase
        end
        if (rd) begin
            unique case (reg_addr_e'(addr))
                RA_MODE:   st_d.rdata = st_q.mode;
                RA_ENABLE: st_d.rdata = {{PAD_W{1'b0}}, st_q.en};
                RA_DIR:    st_d.rdata = {{PAD_W{1'b0}}, st_q.dir};
                RA_FLAG:   st_d.rdata = {{PAD_W{1'b0}}, flags};
                default:   st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata    = st_q.rdata;
    assign mode_vec = st_q.mode;
    assign en_vec   = st_q.en;
    assign dir_vec  = st_q.dir;

endmodule

// File: rtl/pin_event_unit.sv
module pin_event_unit
    import epi_pkg::*;
#(
    parameter int POS_N  = POS_N_DEF,
    parameter int SYNC_N = SYNC_N_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [2*POS_N-1:0]   bus_wdata,
    output logic [2*POS_N-1:0]   bus_rdata,
    input  logic [POS_N-1:0]     ext_pin,
    output logic [POS_N-1:0]     irq_req
);

    localparam int BUS_W = 2 * POS_N;

    logic [POS_N-1:0]   smp_vec;
    logic [2*POS_N-1:0] mode_vec;
    logic [POS_N-1:0]   en_vec;
    logic [POS_N-1:0]   dir_vec;
    logic [POS_N-1:0]   clr_vec;
    logic [POS_N-1:0]   flag_vec;
    logic [POS_N-1:0]   evt_vec;

    epi_sync #(
        .W      (POS_N),
        .STAGES (SYNC_N)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ext_pin),
        .dout  (smp_vec)
    );

    epi_regs #(
        .POS_N (POS_N),
        .BUS_W (BUS_W)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .wdata    (bus_wdata),
        .flags    (flag_vec),
        .rdata    (bus_rdata),
        .mode_vec (mode_vec),
        .en_vec   (en_vec),
        .dir_vec  (dir_vec),
        .clr_vec  (clr_vec)
    );

    for (genvar g = 0; g < POS_N; g++) begin : g_pin
        epi_pin_cell #(
            .RESV (g == 0)
        ) cell_i (
            .clk   (clk),
            .rst_n (rst_n),
            .smp   (smp_vec[g]),
            .mode  (mode_vec[2*g +: 2]),
            .en    (en_vec[g]),
            .clr   (clr_vec[g]),
            .evt   (evt_vec[g]),
            .flag  (flag_vec[g]),
            .req   (irq_req[g])
        );
    end

endmodule

// File: rtl/epi_chk.sv
module epi_chk #(
    parameter int POS_N = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         bus_addr,
    input logic               bus_wr,
    input logic [2*POS_N-1:0] bus_wdata,
    input logic [POS_N-1:0]   irq_req,
    input logic [POS_N-1:0]   en_q,
    input logic [POS_N-1:0]   flag_q,
    input logic [POS_N-1:0]   evt
);

    logic flag_wr;
    assign flag_wr = bus_wr && (bus_addr == 2'd3);

    // R7
    req_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req & ~en_q) == '0);

    // R9
    resv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req[0] && !flag_q[0]);

    // R6
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr |=> ((flag_q & $past(bus_wdata[POS_N-1:0]) & ~$past(evt)) == '0));

    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_wr && evt == '0) |=> $stable(flag_q));

    // R10
    edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((flag_q & $past(evt)) == $past(evt)));

endmodule

bind pin_event_unit epi_chk #(.POS_N(POS_N)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .irq_req   (irq_req),
    .en_q      (en_vec),
    .flag_q    (flag_vec),
    .evt       (evt_vec)
);

// File: tb/pin_event_unit_tb_top.sv
`timescale 1ns/1ps
module pin_event_unit_tb_top;

    localparam int P  = 8;
    localparam int BW = 2 * P;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [BW-1:0] bus_wdata = '0;
    logic [BW-1:0] bus_rdata;
    logic [P-1:0]  pins = '1;
    logic [P-1:0]  irq_req;

    pin_event_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ext_pin   (pins),
        .irq_req   (irq_req)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          due;
        bit          is_rd;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t sbq[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    // Monitor: pops items whose result is due and compares.
    always @(negedge clk) begin
        #1;
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            item_t       it;
            logic [15:0] act;
            it  = sbq.pop_front();
            act = it.is_rd ? bus_rdata : {8'h00, irq_req};
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd_expect(input logic [1:0] a, input logic [15:0] e, input string tag);
        bus_addr = a;
        bus_rd   = 1'b1;
        sbq.push_back('{due: cyc + 1, is_rd: 1'b1, exp: e, tag: tag});
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic irq_expect(input logic [7:0] e, input string tag);
        sbq.push_back('{due: cyc, is_rd: 1'b0, exp: {8'h00, e}, tag: tag});
    endtask

    initial begin
        #(8 * 50000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] mv;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);

        // R1 reset state
        irq_expect(8'h00, "R1 irq after reset");
        rd_expect(2'd0, 16'h0000, "R1 mode reset");
        rd_expect(2'd1, 16'h0000, "R1 enable reset");
        rd_expect(2'd2, 16'h0000, "R1 dir reset");
        rd_expect(2'd3, 16'h0000, "R1 flag reset");

        // R2 full width readback and field rewrite
        wr_reg(2'd0, 16'hA5C3);
        rd_expect(2'd0, 16'hA5C3, "R2 mode readback");
        mv = (16'hA5C3 & ~(16'h3 << 6)) | (16'h1 << 6);
        wr_reg(2'd0, mv);
        rd_expect(2'd0, mv, "R2 field rewrite");

        // R8 / R11 direction store and upper bits
        wr_reg(2'd2, 16'hFF5A);
        rd_expect(2'd2, 16'h005A, "R8 R11 dir readback");
        irq_expect(8'h00, "R8 dir no effect");
        wr_reg(2'd1, 16'hFF00);
        rd_expect(2'd1, 16'h0000, "R11 upper enable bits ignored");

        // Setup: p0 rise, p1 level, p2 rise, p3 fall, p4 both, p5 rise
        wr_reg(2'd0, 16'h0791);
        wr_reg(2'd1, 16'h00DF);
        irq_expect(8'h00, "R3 idle high pins");

        // R5 level, R4 latency
        pins[1] = 1'b0;
        wait_n(1);
        irq_expect(8'h00, "R4 level not before 2nd edge");
        wait_n(1);
        irq_expect(8'h02, "R5 level low asserts");
        rd_expect(2'd3, 16'h0000, "R5 level sets no flag");
        pins[1] = 1'b1;
        wait_n(2);
        irq_expect(8'h00, "R5 level release");

        // R3 rise
        pins[2] = 1'b0;
        wait_n(3);
        irq_expect(8'h00, "R3 rise ignores fall");
        pins[2] = 1'b1;
        wait_n(2);
        irq_expect(8'h00, "R4 edge not before 3rd edge");
        wait_n(1);
        irq_expect(8'h04, "R3 rise");

        // R3 fall
        pins[3] = 1'b0;
        wait_n(3);
        irq_expect(8'h0C, "R3 fall");
        pins[3] = 1'b1;
        wait_n(3);
        irq_expect(8'h0C, "R3 fall ignores rise");

        // R3 both
        pins[4] = 1'b0;
        wait_n(3);
        irq_expect(8'h1C, "R3 both");
        rd_expect(2'd3, 16'h001C, "R6 flags latched");

        // R6 write-1-to-clear
        wr_reg(2'd3, 16'h0004);
        irq_expect(8'h18, "R6 clear one flag");
        rd_expect(2'd3, 16'h0018, "R6 zero bits keep flags");
        wr_reg(2'd3, 16'h0018);
        irq_expect(8'h00, "R6 clear rest");

        // R10 edge coincides with clear
        pins[4] = 1'b1;
        wait_n(3);
        irq_expect(8'h10, "R10 first edge");
        pins[4] = 1'b0;
        wait_n(2);
        wr_reg(2'd3, 16'h0010);
        irq_expect(8'h10, "R10 edge wins over clear");
        rd_expect(2'd3, 16'h0010, "R10 flag kept");
        wr_reg(2'd3, 16'h0010);
        irq_expect(8'h00, "R10 later clear");

        // R7 disabled pin still latches
        pins[5] = 1'b0;
        wait_n(3);
        pins[5] = 1'b1;
        wait_n(3);
        irq_expect(8'h00, "R7 disabled no request");
        rd_expect(2'd3, 16'h0020, "R7 flag latched while disabled");
        wr_reg(2'd1, 16'h00FF);
        irq_expect(8'h20, "R7 enable releases pending");
        wr_reg(2'd3, 16'h0020);
        irq_expect(8'h00, "R7 cleared");

        // R9 reserved position
        pins[0] = 1'b0;
        wait_n(3);
        pins[0] = 1'b1;
        wait_n(3);
        irq_expect(8'h00, "R9 reserved no request");
        rd_expect(2'd3, 16'h0000, "R9 reserved no flag");

        // R2 one-field change leaves others working
        mv = (16'h0791 & ~(16'h3 << 12)) | (16'h1 << 12);
        wr_reg(2'd0, mv);
        rd_expect(2'd0, mv, "R2 rmw readback");
        pins[6] = 1'b0;
        wait_n(3);
        irq_expect(8'h00, "R2 new rise field ignores fall");
        pins[6] = 1'b1;
        wait_n(3);
        irq_expect(8'h40, "R2 new field active");
        pins[2] = 1'b0;
        wait_n(3);
        pins[2] = 1'b1;
        wait_n(3);
        irq_expect(8'h44, "R2 other fields intact");

        wait_n(3);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule